// File: doc/BRIEF.md
# Sideband Message Bus Bridge

This block sits behind a host configuration-space decoder and converts plain 32-bit register accesses into transactions on an internal sideband message bus. The host sees three words: a command word that names the opcode, target port, low offset byte and byte enables; a data word that stages write data and returns read results; and an extension word that supplies the upper 24 bits of the target offset.

A host write to the command word launches a transaction when the opcode is a known read or write. The bridge then holds a request toward the sideband until the target answers with a one-cycle done pulse. Read data is captured into the data word on completion. While a transaction is outstanding the bridge reports busy and refuses new launches and data updates, so the request fields stay stable. An unknown opcode is recorded in the command word but starts nothing.

Top module: `sbmb_bridge`

## Requirements
- R1: After reset, busy and sb_req are 0, and the command, data and extension words all read as zero.
- R2: Host offsets are 0xD0 (command), 0xD4 (data), 0xD8 (extension). The command word reads back with bits [3:0] forced to zero; the extension word reads back with bits [7:0] forced to zero; the data word reads back whole.
- R3: Command layout is opcode [31:24], port [23:16], low offset [15:8], byte enables [7:4]. Opcode 0x11 (write) drives sb_opcode, sb_port, sb_be from the command and sb_wdata from the data word staged before launch; sb_req rises on the clock edge that accepts the command write.
- R4: sb_offset equals {extension[31:8], command[15:8]}, using the extension value held when the command is written.
- R5: Opcode 0x10 (read) captures sb_rdata into the data word on the clock edge where sb_done is high.
- R6: busy and sb_req stay high from launch until the edge with sb_done, then drop; reads of the data word while busy return the last completed value.
- R7: A command with any opcode other than 0x10 or 0x11 raises neither sb_req nor busy and leaves the data word unchanged.
- R8: While busy, host writes to the command and data words are ignored: no relaunch, request fields stable, data word unchanged.
- R9: sb_done arriving while not busy has no effect on the data word or busy.
- R10: Reads of any other host offset return zero, and writes to them change no visible state.
- R11: Completion of a write transaction leaves the data word holding the staged write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Host write strobe, one access per cycle |
| cfg_addr | input | CFG_AW | Host configuration offset |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Host read data for cfg_addr (combinational) |
| busy | output | 1 | Transaction outstanding |
| sb_req | output | 1 | Sideband request, held until sb_done |
| sb_opcode | output | 8 | Sideband opcode |
| sb_port | output | 8 | Sideband target port |
| sb_offset | output | 32 | Sideband register offset |
| sb_be | output | 4 | Sideband byte enables |
| sb_wdata | output | 32 | Sideband write data |
| sb_rdata | input | 32 | Sideband read data, valid with sb_done |
| sb_done | input | 1 | Sideband completion pulse |

## Verification
The bench builds the bridge with the default CFG_AW of 8, so the whole host offset space is addressable and offsets next to the three mapped words (such as 0xDC and 0x00) can be probed for R10. Random rounds vary opcode, port, offset, byte enables, extension and completion latency from zero to several cycles, which brings back-to-back launches, long busy windows with host traffic inside them, and unknown opcodes within reach.

// File: rtl/sbmb_pkg.sv
package sbmb_pkg;
  localparam int WORD_W  = 32;
  localparam int OP_W    = 8;
  localparam int PORT_W  = 8;
  localparam int OFFLO_W = 8;
  localparam int BE_W    = 4;
  localparam int OFFHI_W = WORD_W - OFFLO_W;

  localparam logic [OP_W-1:0] OP_READ  = 8'h10;
  localparam logic [OP_W-1:0] OP_WRITE = 8'h11;

  localparam logic [7:0] HOFF_CMD  = 8'hD0;
  localparam logic [7:0] HOFF_DATA = 8'hD4;
  localparam logic [7:0] HOFF_EXT  = 8'hD8;

  function automatic logic [OP_W-1:0] cmd_opcode(input logic [WORD_W-1:0] w);
    return w[31:24];
  endfunction

  function automatic logic [PORT_W-1:0] cmd_port(input logic [WORD_W-1:0] w);
    return w[23:16];
  endfunction

  function automatic logic [BE_W-1:0] cmd_be(input logic [WORD_W-1:0] w);
    return w[7:4];
  endfunction

  function automatic logic [WORD_W-1:0] join_offset(input logic [WORD_W-1:0] ext,
                                                    input logic [WORD_W-1:0] cmd);
    return {ext[WORD_W-1:OFFLO_W], cmd[15:8]};
  endfunction

  function automatic logic opcode_known(input logic [OP_W-1:0] op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction
endpackage

// File: rtl/sbmb_hostregs.sv
module sbmb_hostregs
  import sbmb_pkg::*;
#(
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              busy,
  input  logic              rd_load,
  input  logic [WORD_W-1:0] rd_value,
  output logic              launch,
  output logic              data_wr_hit,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] data_q,
  output logic [WORD_W-1:0] ext_q
);
  localparam logic [CFG_AW-1:0] A_CMD  = CFG_AW'(HOFF_CMD);
  localparam logic [CFG_AW-1:0] A_DATA = CFG_AW'(HOFF_DATA);
  localparam logic [CFG_AW-1:0] A_EXT  = CFG_AW'(HOFF_EXT);

  logic cmd_hit, ext_hit;

  assign cmd_hit     = cfg_wr_en && (cfg_addr == A_CMD);
  assign data_wr_hit = cfg_wr_en && (cfg_addr == A_DATA);
  assign ext_hit     = cfg_wr_en && (cfg_addr == A_EXT);
  assign launch      = cmd_hit && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      ext_q  <= '0;
    end else begin
      if (launch)
        cmd_q <= {cfg_wdata[WORD_W-1:4], 4'b0000};
      if (rd_load)
        data_q <= rd_value;
      else if (data_wr_hit && !busy)
        data_q <= cfg_wdata;
      if (ext_hit)
        ext_q <= {cfg_wdata[WORD_W-1:OFFLO_W], {OFFLO_W{1'b0}}};
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_CMD)       cfg_rdata = cmd_q;
    else if (cfg_addr == A_DATA) cfg_rdata = data_q;
    else if (cfg_addr == A_EXT)  cfg_rdata = ext_q;
  end
endmodule

// File: rtl/sbmb_launcher.sv
module sbmb_launcher
  import sbmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [WORD_W-1:0] ext_word,
  input  logic [WORD_W-1:0] data_word,
  input  logic              sb_done,
  input  logic [WORD_W-1:0] sb_rdata,
  output logic              busy,
  output logic [OP_W-1:0]   sb_opcode,
  output logic [PORT_W-1:0] sb_port,
  output logic [WORD_W-1:0] sb_offset,
  output logic [BE_W-1:0]   sb_be,
  output logic [WORD_W-1:0] sb_wdata,
  output logic              rd_load,
  output logic [WORD_W-1:0] rd_value
);
  logic start, finish;

  assign start  = launch && opcode_known(cmd_opcode(cmd_word));
  assign finish = busy && sb_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sb_opcode <= '0;
      sb_port   <= '0;
      sb_offset <= '0;
      sb_be     <= '0;
      sb_wdata  <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      sb_opcode <= cmd_opcode(cmd_word);
      sb_port   <= cmd_port(cmd_word);
      sb_offset <= join_offset(ext_word, cmd_word);
      sb_be     <= cmd_be(cmd_word);
      sb_wdata  <= data_word;
    end else if (finish) begin
      busy <= 1'b0;
    end
  end

  assign rd_load  = finish && (sb_opcode == OP_READ);
  assign rd_value = sb_rdata;
endmodule

// File: rtl/sbmb_bridge.sv
module sbmb_bridge
  import sbmb_pkg::*;
#(
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              busy,
  output logic              sb_req,
  output logic [7:0]        sb_opcode,
  output logic [7:0]        sb_port,
  output logic [31:0]       sb_offset,
  output logic [3:0]        sb_be,
  output logic [31:0]       sb_wdata,
  input  logic [31:0]       sb_rdata,
  input  logic              sb_done
);
  logic              launch, data_wr_hit, rd_load;
  logic [WORD_W-1:0] cmd_q, data_q, ext_q, rd_value;

  sbmb_hostregs #(.CFG_AW(CFG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .busy(busy),
    .rd_load(rd_load), .rd_value(rd_value),
    .launch(launch), .data_wr_hit(data_wr_hit),
    .cmd_q(cmd_q), .data_q(data_q), .ext_q(ext_q)
  );

  sbmb_launcher launch_i (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .cmd_word(cfg_wdata), .ext_word(ext_q), .data_word(data_q),
    .sb_done(sb_done), .sb_rdata(sb_rdata),
    .busy(busy), .sb_opcode(sb_opcode), .sb_port(sb_port),
    .sb_offset(sb_offset), .sb_be(sb_be), .sb_wdata(sb_wdata),
    .rd_load(rd_load), .rd_value(rd_value)
  );

  assign sb_req = busy;
endmodule

// File: rtl/sbmb_bridge_chk.sv
module sbmb_bridge_chk
  import sbmb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              sb_req,
  input logic              sb_done,
  input logic [OP_W-1:0]   sb_opcode,
  input logic [WORD_W-1:0] sb_offset,
  input logic [WORD_W-1:0] sb_wdata,
  input logic [WORD_W-1:0] data_q,
  input logic              data_wr_hit
);
  assert_hold_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sb_done |=> busy);

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sb_done |=> !busy);

  assert_known_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_req) |-> (sb_opcode == OP_READ || sb_opcode == OP_WRITE));

  assert_stable_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req && !sb_done |=> $stable(sb_offset) && $stable(sb_wdata) && $stable(sb_opcode));

  assert_staged_wdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_req) && sb_opcode == OP_WRITE |-> sb_wdata == $past(data_q));

  assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && sb_done && !data_wr_hit |=> $stable(data_q));

  assert_wr_keeps_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sb_done && sb_opcode == OP_WRITE |=> $stable(data_q));
endmodule

bind sbmb_bridge sbmb_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sb_req(sb_req), .sb_done(sb_done),
  .sb_opcode(sb_opcode), .sb_offset(sb_offset), .sb_wdata(sb_wdata),
  .data_q(data_q), .data_wr_hit(data_wr_hit)
);

// File: tb/sbmb_bridge_tb.sv
module sbmb_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        busy, sb_req;
  logic [7:0]  sb_opcode, sb_port;
  logic [31:0] sb_offset, sb_wdata;
  logic [3:0]  sb_be;
  logic [31:0] sb_rdata = '0;
  logic        sb_done = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sbmb_bridge #(.CFG_AW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .sb_req(sb_req),
    .sb_opcode(sb_opcode), .sb_port(sb_port), .sb_offset(sb_offset),
    .sb_be(sb_be), .sb_wdata(sb_wdata), .sb_rdata(sb_rdata), .sb_done(sb_done)
  );

  function automatic logic [31:0] mk_cmd(logic [7:0] op, logic [7:0] port,
                                         logic [7:0] lo, logic [3:0] be);
    return (32'(op) << 24) | (32'(port) << 16) | (32'(lo) << 8) | (32'(be) << 4);
  endfunction

  function automatic logic [31:0] exp_offset(logic [31:0] ext, logic [7:0] lo);
    return ((ext >> 8) << 8) + 32'(lo);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic host_rd(logic [7:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic complete(logic [31:0] rd);
    @(negedge clk);
    sb_done = 1'b1; sb_rdata = rd;
    @(negedge clk);
    sb_done = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rv, exp_data, ext, dat, rdv;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 0 && sb_req == 0, "R1 idle", {30'b0, busy, sb_req}, 0);
    host_rd(8'hD0, rv); chk(rv == 0, "R1 cmd", rv, 0);
    host_rd(8'hD4, rv); chk(rv == 0, "R1 data", rv, 0);
    host_rd(8'hD8, rv); chk(rv == 0, "R1 ext", rv, 0);

    // R2 readback masks
    host_wr(8'hD8, 32'hA5A5_A5FF);
    host_rd(8'hD8, rv); chk(rv == 32'hA5A5_A500, "R2 ext mask", rv, 32'hA5A5_A500);
    host_wr(8'hD4, 32'h1234_5678);
    host_rd(8'hD4, rv); chk(rv == 32'h1234_5678, "R2 data", rv, 32'h1234_5678);
    host_wr(8'hD0, 32'h7700_000F);   // unknown op, reserved bits set
    host_rd(8'hD0, rv); chk(rv == 32'h7700_0000, "R2 cmd mask", rv, 32'h7700_0000);
    // R7 unknown opcode
    chk(busy == 0 && sb_req == 0, "R7 no launch", {31'b0, sb_req}, 0);
    host_rd(8'hD4, rv); chk(rv == 32'h1234_5678, "R7 data kept", rv, 32'h1234_5678);
    exp_data = 32'h1234_5678;

    // R10 unmapped offsets
    host_wr(8'hDC, 32'hFFFF_FFFF);
    host_wr(8'h00, 32'hFFFF_FFFF);
    host_rd(8'hDC, rv); chk(rv == 0, "R10 read DC", rv, 0);
    host_rd(8'h00, rv); chk(rv == 0, "R10 read 00", rv, 0);
    host_rd(8'hD4, rv); chk(rv == exp_data, "R10 data untouched", rv, exp_data);
    host_rd(8'hD8, rv); chk(rv == 32'hA5A5_A500, "R10 ext untouched", rv, 32'hA5A5_A500);
    chk(busy == 0, "R10 no launch", {31'b0, busy}, 0);

    // R9 done while idle
    complete(32'hDEAD_BEEF);
    host_rd(8'hD4, rv); chk(rv == exp_data, "R9 idle done", rv, exp_data);
    chk(busy == 0, "R9 busy", {31'b0, busy}, 0);

    // R8 writes while busy; R5 read capture
    host_wr(8'hD0, mk_cmd(8'h10, 8'h05, 8'h44, 4'hF));
    chk(sb_req == 1 && busy == 1, "R6 launch", {31'b0, sb_req}, 1);
    chk(sb_offset == 32'hA5A5_A544, "R4 offset", sb_offset, 32'hA5A5_A544);
    host_wr(8'hD0, mk_cmd(8'h11, 8'h09, 8'h12, 4'h3));
    chk(sb_opcode == 8'h10 && sb_port == 8'h05, "R8 no relaunch",
        {16'b0, sb_opcode, sb_port}, {16'b0, 8'h10, 8'h05});
    host_rd(8'hD0, rv);
    chk(rv == mk_cmd(8'h10, 8'h05, 8'h44, 4'hF), "R8 cmd kept", rv,
        mk_cmd(8'h10, 8'h05, 8'h44, 4'hF));
    host_wr(8'hD4, 32'h0BAD_0BAD);
    host_rd(8'hD4, rv); chk(rv == exp_data, "R8 data kept", rv, exp_data);
    complete(32'hCAFE_F00D);
    exp_data = 32'hCAFE_F00D;
    host_rd(8'hD4, rv); chk(rv == exp_data, "R5 captured", rv, exp_data);
    chk(busy == 0 && sb_req == 0, "R6 release", {31'b0, busy}, 0);

    // random rounds
    for (int i = 0; i < 60; i++) begin
      logic [7:0] op, port, lo;
      logic [3:0] be;
      int lat, pick;
      bit known;
      pick = $urandom_range(0, 9);
      op   = (pick < 4) ? 8'h10 : (pick < 8) ? 8'h11 : 8'($urandom_range(0, 255));
      port = 8'($urandom); lo = 8'($urandom); be = 4'($urandom);
      ext  = $urandom; dat = $urandom; rdv = $urandom;
      lat  = $urandom_range(0, 5);
      known = (op == 8'h10) || (op == 8'h11);
      host_wr(8'hD4, dat); exp_data = dat;
      host_wr(8'hD8, ext);
      host_wr(8'hD0, mk_cmd(op, port, lo, be));
      if (!known) begin
        chk(sb_req == 0 && busy == 0, "R7 random unknown", {31'b0, sb_req}, 0);
        host_rd(8'hD4, rv); chk(rv == exp_data, "R7 random data", rv, exp_data);
        continue;
      end
      chk(sb_req == 1, "R6 random launch", {31'b0, sb_req}, 1);
      chk(sb_offset == exp_offset(ext, lo), "R4 random offset", sb_offset, exp_offset(ext, lo));
      chk(sb_opcode == op && sb_port == port && sb_be == be, "R3 random fields",
          {12'b0, sb_opcode, sb_port, sb_be}, {12'b0, op, port, be});
      if (op == 8'h11) chk(sb_wdata == dat, "R3 random wdata", sb_wdata, dat);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        host_rd(8'hD4, rv); chk(rv == exp_data, "R6 busy read", rv, exp_data);
        chk(busy == 1, "R6 busy held", {31'b0, busy}, 1);
      end
      complete(rdv);
      if (op == 8'h10) exp_data = rdv;
      host_rd(8'hD4, rv);
      chk(rv == exp_data, (op == 8'h10) ? "R5 random read" : "R11 random write", rv, exp_data);
      chk(busy == 0, "R6 random release", {31'b0, busy}, 0);
    end

    summary();
  end
endmodule